// File: doc/BRIEF.md
# Multi-Format Audio Serial Port

This block links a stereo sample stream to a serial audio bus in two directions. In the record direction it takes a left/right sample pair from a parallel port and shifts it out, MSB first, on a serial data pin. In the playback direction it collects serial bits from a data pin and presents the left/right pair on a parallel port with a one-cycle valid pulse. An external master supplies a shared bit clock and one frame clock for each direction. The block oversamples all three clocks with its own system clock.

Four framings are chosen at run time by a 2-bit code: right-aligned, left-aligned, one-bit-delayed (I2S style) and pulse-framed (DSP/PCM). The word length is chosen from four values. A polarity bit inverts the meaning of the frame clock, or selects the pulse-framed submode. A second bit inverts the bit clock, and a third exchanges the two received channels. Samples sit LSB-justified in the 32-bit parallel ports.

Top module: `aserial_port`

## Requirements
- R1: After reset the serial output, the valid pulse and both received sample ports are 0.
- R2: Format code 01 (left-aligned): the MSB occupies bit slot 0 after a frame-clock transition. With polarity 0 the left channel is sent while the frame clock is high.
- R3: Format code 10 (one-bit-delayed): the MSB occupies bit slot 1 after a frame-clock transition. With polarity 0 the left channel is sent while the frame clock is low.
- R4: Format code 00 (right-aligned): the LSB occupies the last slot before the next frame-clock transition. The transmitter takes the half-frame length from the half that precedes it. With polarity 0 the left channel is sent while the frame clock is high.
- R5: Format code 11 (pulse-framed): a rising frame clock marks the frame start, and the right word follows the last left bit with no gap. With polarity 1 the left MSB is in slot 0 of the frame; with polarity 0 it is in slot 1.
- R6: Word-length code 00/01/10/11 selects 16/20/24/32 bits. Received words are LSB-justified, and the bits above the word length read 0.
- R7: Serial input is sampled on a rising edge of the effective bit clock, and the serial output changes only after a falling edge. Setting the inversion bit makes the effective bit clock the complement of the pin.
- R8: Outside the pulse-framed format, polarity 1 swaps which frame-clock level denotes the left channel.
- R9: With the swap bit set, the received left word appears on the right output port and the received right word on the left output port.
- R10: Output slots that carry no sample bit are driven to 0. Received bits outside a word's slots leave the presented words unchanged.
- R11: The valid output pulses for exactly one system clock, one clock after the rise event that completes the right word. A record pair is latched whenever the record valid input is high. It is sent from the start of the next left word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Framing code: 00 right, 01 left, 10 delayed, 11 pulse |
| wlen_sel | input | 2 | Word-length code: 16/20/24/32 bits |
| frame_pol | input | 1 | Frame sense inversion or pulse submode |
| bclk_inv | input | 1 | Inverts the bit clock before use |
| pb_swap | input | 1 | Exchanges the received left and right words |
| bclk_in | input | 1 | Serial bit clock |
| rec_fclk | input | 1 | Record-direction frame clock |
| pb_fclk | input | 1 | Playback-direction frame clock |
| pb_sdata | input | 1 | Playback serial data |
| rec_sdata | output | 1 | Record serial data |
| rec_valid | input | 1 | Latches rec_left and rec_right |
| rec_left | input | 32 | Record left sample, LSB-justified |
| rec_right | input | 32 | Record right sample, LSB-justified |
| pb_valid | output | 1 | One-cycle pulse when a pair is received |
| pb_left | output | 32 | Received left sample |
| pb_right | output | 32 | Received right sample |

## Verification
A slot counter that slips, or a wrong delay for a format, moves a word by one bit position. Every bit after that point then shows a wrong value on the serial output within the same half-frame. An error in the half-length register or the snapshot register shows as a shifted or stale word at the start of the next left word. On the receive side, a wrong completion slot shows as a corrupted word, or as a valid pulse at the wrong time or count, within one frame. The bench therefore compares every bit slot of the record stream and every playback pulse against a model built from frame geometry.

// File: rtl/aserial_port.sv
module aserial_port #(
  parameter int DW     = 32,
  parameter int SLOT_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt_sel,
  input  logic [1:0]    wlen_sel,
  input  logic          frame_pol,
  input  logic          bclk_inv,
  input  logic          pb_swap,
  input  logic          bclk_in,
  input  logic          rec_fclk,
  input  logic          pb_fclk,
  input  logic          pb_sdata,
  output logic          rec_sdata,
  input  logic          rec_valid,
  input  logic [DW-1:0] rec_left,
  input  logic [DW-1:0] rec_right,
  output logic          pb_valid,
  output logic [DW-1:0] pb_left,
  output logic [DW-1:0] pb_right
);
  localparam logic [1:0] F_RJ = 2'b00, F_LJ = 2'b01, F_I2S = 2'b10, F_DSP = 2'b11;
  localparam int IW = $clog2(DW);
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic bq, bd, rfq, pfq, pdq;
  logic rise_ev, fall_ev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bq <= 1'b0; bd <= 1'b0; rfq <= 1'b0; pfq <= 1'b0; pdq <= 1'b0;
    end else begin
      bq  <= bclk_in ^ bclk_inv;
      bd  <= bq;
      rfq <= rec_fclk;
      pfq <= pb_fclk;
      pdq <= pb_sdata;
    end

  assign rise_ev = bq & ~bd;
  assign fall_ev = ~bq & bd;

  int wbits, dly;
  logic dsp, rj;
  logic [DW-1:0] mask;

  always_comb begin
    case (wlen_sel)
      2'b00:   wbits = 16;
      2'b01:   wbits = 20;
      2'b10:   wbits = 24;
      default: wbits = 32;
    endcase
    dsp  = (fmt_sel == F_DSP);
    rj   = (fmt_sel == F_RJ);
    dly  = (fmt_sel == F_I2S || (dsp && !frame_pol)) ? 1 : 0;
    mask = (wbits >= DW) ? '1 : ((DW'(1) << wbits) - 1'b1);
  end

  logic t_left, r_left;
  assign t_left = (fmt_sel == F_I2S) ? ~(rfq ^ frame_pol) : (rfq ^ frame_pol);
  assign r_left = (fmt_sel == F_I2S) ? ~(pfq ^ frame_pol) : (pfq ^ frame_pol);

  // transmit (record) path
  logic              tf_prev, t_start, t_snap, t_bit;
  logic [SLOT_W-1:0] tslot, tlen, t_inc, t_nslot;
  logic [DW-1:0]     hold_l, hold_r, act_l, act_r, wl_c, wr_c;
  int                t_s, t_n, t_idx;
  logic [DW-1:0]     t_w;

  always_comb begin
    t_inc   = (tslot == SLOT_MAX) ? tslot : tslot + 1'b1;
    t_start = dsp ? (rfq & ~tf_prev) : (rfq ^ tf_prev);
    t_nslot = t_start ? '0 : t_inc;
    t_snap  = t_start & (dsp | t_left);
    wl_c    = t_snap ? hold_l : act_l;
    wr_c    = t_snap ? hold_r : act_r;
    t_s     = int'(t_nslot);
    t_n     = t_start ? int'(t_inc) : int'(tlen);
    t_w     = t_left ? wl_c : wr_c;
    if (dsp) begin
      if (t_s < dly + wbits) begin
        t_idx = dly + wbits - 1 - t_s;
        t_w   = wl_c;
      end else begin
        t_idx = dly + 2 * wbits - 1 - t_s;
        t_w   = wr_c;
      end
    end else if (rj) begin
      t_idx = t_n - 1 - t_s;
    end else begin
      t_idx = dly + wbits - 1 - t_s;
    end
    t_bit = (t_idx >= 0 && t_idx < wbits) ? t_w[t_idx[IW-1:0]] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tf_prev <= 1'b0; tslot <= '0; tlen <= '0;
      hold_l <= '0; hold_r <= '0; act_l <= '0; act_r <= '0;
      rec_sdata <= 1'b0;
    end else begin
      if (rec_valid) begin
        hold_l <= rec_left;
        hold_r <= rec_right;
      end
      if (fall_ev) begin
        tf_prev <= rfq;
        tslot   <= t_nslot;
        if (t_start) tlen <= t_inc;
        if (t_snap) begin
          act_l <= hold_l;
          act_r <= hold_r;
        end
        rec_sdata <= t_bit;
      end
    end

  // receive (playback) path
  logic              pf_prev, rleft, r_start;
  logic [SLOT_W-1:0] rslot, r_inc, r_nslot;
  logic [DW-1:0]     sh, shn, pl, pr;
  int                r_s;

  always_comb begin
    r_inc   = (rslot == SLOT_MAX) ? rslot : rslot + 1'b1;
    r_start = dsp ? (pfq & ~pf_prev) : (pfq ^ pf_prev);
    r_nslot = r_start ? '0 : r_inc;
    r_s     = int'(r_nslot);
    shn     = {sh[DW-2:0], pdq};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pf_prev <= 1'b0; rleft <= 1'b0; rslot <= '0;
      sh <= '0; pl <= '0; pr <= '0; pb_valid <= 1'b0;
    end else begin
      pb_valid <= 1'b0;
      if (rise_ev) begin
        pf_prev <= pfq;
        rslot   <= r_nslot;
        rleft   <= r_left;
        sh      <= shn;
        if (rj) begin
          if (r_start) begin
            if (rleft) pl <= sh & mask;
            else begin
              pr       <= sh & mask;
              pb_valid <= 1'b1;
            end
          end
        end else if (dsp) begin
          if (r_s == dly + wbits - 1) pl <= shn & mask;
          if (r_s == dly + 2 * wbits - 1) begin
            pr       <= shn & mask;
            pb_valid <= 1'b1;
          end
        end else if (r_s == dly + wbits - 1) begin
          if (r_left) pl <= shn & mask;
          else begin
            pr       <= shn & mask;
            pb_valid <= 1'b1;
          end
        end
      end
    end

  assign pb_left  = pb_swap ? pr : pl;
  assign pb_right = pb_swap ? pl : pr;

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pb_valid |=> !pb_valid); // R11
  AST_RX_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    pb_valid |-> $past(rise_ev)); // R7
  AST_TX_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rec_sdata) |-> $past(fall_ev)); // R7
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && fmt_sel == F_LJ && int'(t_nslot) >= wbits) |=> !rec_sdata); // R10
endmodule

// File: tb/aserial_port_tb.sv
module aserial_port_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [1:0] fmt_sel = 2'b00, wlen_sel = 2'b00;
  logic frame_pol = 0, bclk_inv = 0, pb_swap = 0;
  logic bclk_in = 1, rec_fclk = 0, pb_fclk = 0, pb_sdata = 0;
  logic rec_valid = 0;
  logic [31:0] rec_left = 0, rec_right = 0;
  logic rec_sdata, pb_valid;
  logic [31:0] pb_left, pb_right;

  aserial_port u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .wlen_sel(wlen_sel),
    .frame_pol(frame_pol), .bclk_inv(bclk_inv), .pb_swap(pb_swap),
    .bclk_in(bclk_in), .rec_fclk(rec_fclk), .pb_fclk(pb_fclk), .pb_sdata(pb_sdata),
    .rec_sdata(rec_sdata), .rec_valid(rec_valid), .rec_left(rec_left),
    .rec_right(rec_right), .pb_valid(pb_valid), .pb_left(pb_left), .pb_right(pb_right));

  int errors = 0, checks = 0;
  logic armed = 0;
  logic [31:0] q_l[$], q_r[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // playback pulses compared against the expectation queue on every clock
  always @(negedge clk) begin
    if (rst_n && armed && pb_valid) begin
      if (q_l.size() == 0) chk("R11 unexpected pulse", 32'd1, 32'd0);
      else begin
        chk(pb_swap ? "R9 left port" : "R6 left port", pb_left, q_l.pop_front());
        chk(pb_swap ? "R9 right port" : "R6 right port", pb_right, q_r.pop_front());
      end
    end
  end

  function automatic int wl_bits(input logic [1:0] c);
    return (c == 2'b00) ? 16 : (c == 2'b01) ? 20 : (c == 2'b10) ? 24 : 32;
  endfunction

  function automatic logic [31:0] wmask(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  // {carries data, bit} for frame slot s
  function automatic logic [1:0] slot_info(input logic [1:0] fm, input int w, input int n,
                                           input logic pol, input int s,
                                           input logic [31:0] l, input logic [31:0] r);
    int k, d;
    logic [31:0] wd;
    if (fm == 2'b11) begin
      d = pol ? 0 : 1;
      if (s >= d && s < d + w) return {1'b1, l[w-1-(s-d)]};
      if (s >= d + w && s < d + 2*w) return {1'b1, r[w-1-(s-d-w)]};
      return 2'b00;
    end
    k  = s % n;
    wd = (s < n) ? l : r;
    case (fm)
      2'b00: if (k >= n - w) return {1'b1, wd[n-1-k]};
      2'b01: if (k < w) return {1'b1, wd[w-1-k]};
      default: if (k >= 1 && k <= w) return {1'b1, wd[w-k]};
    endcase
    return 2'b00;
  endfunction

  task automatic do_slot(input logic fb, input logic db, output logic rs);
    @(negedge clk);
    bclk_in = bclk_inv; rec_fclk = fb; pb_fclk = fb; pb_sdata = db;
    repeat (4) @(negedge clk);
    bclk_in = ~bclk_inv;
    repeat (2) @(negedge clk);
    rs = rec_sdata;
    @(negedge clk);
  endtask

  task automatic run(input logic [1:0] fm, input logic [1:0] wc, input logic pol,
                     input logic inv, input logic swp, input int n);
    localparam int NF = 5;
    logic [31:0] pl_a[NF], pr_a[NF], rl_a[NF], rr_a[NF];
    int w;
    logic lvl, fb, rs;
    logic [1:0] pi, ri;
    string tag;
    w = wl_bits(wc);
    @(negedge clk);
    rst_n = 0;
    fmt_sel = fm; wlen_sel = wc; frame_pol = pol; bclk_inv = inv; pb_swap = swp;
    bclk_in = ~inv;
    for (int i = 0; i < NF; i++) begin
      pl_a[i] = $urandom() & wmask(w); pr_a[i] = $urandom() & wmask(w);
      rl_a[i] = $urandom() & wmask(w); rr_a[i] = $urandom() & wmask(w);
    end
    for (int i = 1; i < NF - 1; i++) begin
      q_l.push_back(swp ? pr_a[i] : pl_a[i]);
      q_r.push_back(swp ? pl_a[i] : pr_a[i]);
    end
    repeat (2) @(negedge clk);
    rst_n = 1;
    rec_left = rl_a[0]; rec_right = rr_a[0]; rec_valid = 1;
    @(negedge clk);
    rec_valid = 0;
    lvl = ((fm == 2'b10) ? 1'b0 : 1'b1) ^ pol;
    for (int f = 0; f < NF; f++) begin
      for (int s = 0; s < 2*n; s++) begin
        fb = (fm == 2'b11) ? (s == 0) : ((s < n) ? lvl : ~lvl);
        pi = slot_info(fm, w, n, pol, s, pl_a[f], pr_a[f]);
        ri = slot_info(fm, w, n, pol, s, rl_a[f], rr_a[f]);
        // junk in non-data slots must be ignored (R10)
        do_slot(fb, pi[1] ? pi[0] : 1'($urandom()), rs);
        if (f >= 1) begin
          if (!ri[1]) tag = "R10 pad slot";
          else if (inv) tag = "R7 inverted bit clock";
          else if (pol && fm != 2'b11) tag = "R8 frame sense";
          else case (fm)
            2'b00: tag = "R4 right-aligned bit";
            2'b01: tag = "R2 left-aligned bit";
            2'b10: tag = "R3 delayed bit";
            default: tag = "R5 pulse-framed bit";
          endcase
          chk(tag, {31'd0, rs}, {31'd0, ri[0]});
        end
        if (f == 1 && s == 0) armed = 1;
        if (f == NF - 1 && s == 0) armed = 0;
        if (s == 2*n - 1 && f < NF - 1) begin
          rec_left = rl_a[f+1]; rec_right = rr_a[f+1]; rec_valid = 1; // R11 latch
          @(negedge clk);
          rec_valid = 0;
        end
      end
    end
    chk("R11 pulse count", q_l.size(), 0);
    q_l.delete(); q_r.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 serial out", {31'd0, rec_sdata}, 0);
    chk("R1 valid", {31'd0, pb_valid}, 0);
    chk("R1 left port", pb_left, 0);
    chk("R1 right port", pb_right, 0);
    rst_n = 1;
    run(2'b00, 2'b00, 0, 0, 0, 20); // R4 R6
    run(2'b01, 2'b01, 1, 0, 0, 24); // R2 R8 R6
    run(2'b10, 2'b10, 0, 1, 0, 32); // R3 R7 R6
    run(2'b11, 2'b00, 0, 0, 0, 20); // R5 submode slot 1
    run(2'b11, 2'b11, 1, 0, 0, 34); // R5 submode slot 0, R6 32 bits
    run(2'b10, 2'b11, 1, 0, 1, 34); // R9 R8
    run(2'b00, 2'b11, 1, 1, 1, 40); // R4 R7 R8 R9
    run(2'b01, 2'b00, 0, 0, 0, 16); // R2 R10 full half
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule